// File: doc/BRIEF.md
# I2C Master START Condition Generator

This block produces the START condition on an I2C bus for a master controller. Software writes a command register whose bit 0 requests a START. The block samples both bus lines through a two-flop synchronizer. When both lines are idle-high, it times a first hold interval with its own reloadable down-counter. At the end of that interval it pulls SDA low while SCL remains high, then times a second interval of the same length. When the second interval ends, it clears the request bit and raises a sticky interrupt flag. It leaves SDA pulled low for the byte transfer that follows.

The block aborts to idle and raises a sticky bus-collision flag if the bus is not free when the request arrives. It also aborts if SCL drops during the first interval, or if SDA is found low when the first interval ends. While a START is pending, it rejects two kinds of write: writes to the transmit data buffer, which raise a sticky write-collision flag, and writes to the command register. Both lines are open-drain. The block only ever pulls SDA low, and a high output on `sda_pull_o` means "drive the wire low".

A later accepted command write releases the held SDA line. Software issues such a write, lets the bus settle, and only then requests the next START.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, `sda_pull_o` is 0, `cmd_o` is 0, `txbuf_o` is 0 and every flag output is 0.
- R2: A command write with bit 0 set, made while both lines are high and stable, sets `sda_pull_o` and `start_seen_o` exactly N+2 clock edges after the write edge. N is the value on `reload_i`, and each counter phase lasts N+1 cycles.
- R3: Exactly N+1 edges after SDA is pulled low, `cmd_o[0]` clears and `irq_o` sets, while `sda_pull_o` stays 1.
- R4: If either line is low when a requested START begins, `bcol_o` sets, `cmd_o[0]` clears, SDA is never pulled and `start_seen_o` stays 0.
- R5: If SCL is sampled low during the first phase, the START aborts. `bcol_o` sets, `cmd_o[0]` clears and SDA is not pulled.
- R6: If SDA is sampled low by another driver when the first phase ends, the START aborts with `bcol_o` set and SDA not pulled.
- R7: A transmit-buffer write while `cmd_o[0]` is 1 sets `wcol_o` and leaves `txbuf_o` unchanged. Outside a START, the write stores `txbuf_wdata_i`.
- R8: Command writes while `cmd_o[0]` is 1 are ignored, so `cmd_o` keeps its value until the START completes or aborts.
- R9: `irq_o`, `bcol_o` and `wcol_o` are sticky. Each clears only through its bit of `flag_clr_i`: bit 0 clears `irq_o`, bit 1 clears `bcol_o`, bit 2 clears `wcol_o`.
- R10: An accepted command write made with no START pending releases SDA, so `sda_pull_o` returns to 0 on the write edge. `start_seen_o` clears when the next START request is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | 7 | Baud counter reload value N |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 5 | Command write data, bit 0 requests START |
| txbuf_wr_i | input | 1 | Transmit buffer write strobe |
| txbuf_wdata_i | input | 8 | Transmit buffer write data |
| flag_clr_i | input | 3 | Flag clear strobes: bit0 irq, bit1 bcol, bit2 wcol |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cmd_o | output | 5 | Command register contents |
| txbuf_o | output | 8 | Transmit buffer contents |
| start_seen_o | output | 1 | START condition was placed on the bus |
| irq_o | output | 1 | Sticky START-complete flag |
| bcol_o | output | 1 | Sticky bus-collision flag |
| wcol_o | output | 1 | Sticky write-collision flag |

## Verification
On every cycle, the assertions check the following:
- the command lockout and the buffer protection while a START is pending;
- the stickiness of the three flags;
- that SDA is only ever pulled together with the start flag;
- that the completion flag only rises as the request bit falls;
- the exact decrement of the counter.

Only the bench scenarios can show the properties that depend on the bus and on timing:
- the cycle-exact placement of the SDA edge and of the completion for many random reload values;
- the three collision cases, driven by a modelled open-drain bus;
- the release of the held line by a later command.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2
  } start_st_e;

  localparam int CLR_IRQ  = 0;
  localparam int CLR_BCOL = 1;
  localparam int CLR_WCOL = 2;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // lines reset to released (high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          halt_i,
  input  logic [CW-1:0] val_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= val_i;
      run_q <= 1'b1;
    end else if (halt_i) begin
      run_q <= 1'b0;
    end else if (run_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = run_q && (cnt_q == '0);

  assert_count_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && !load_i && !halt_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int RELOAD_W = 7,
  parameter int CMD_W    = 5,
  parameter int DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                cmd_wr_i,
  input  logic [CMD_W-1:0]    cmd_wdata_i,
  input  logic                txbuf_wr_i,
  input  logic [DATA_W-1:0]   txbuf_wdata_i,
  input  logic [2:0]          flag_clr_i,
  input  logic                sda_i,
  input  logic                scl_i,
  output logic                sda_pull_o,
  output logic [CMD_W-1:0]    cmd_o,
  output logic [DATA_W-1:0]   txbuf_o,
  output logic                start_seen_o,
  output logic                irq_o,
  output logic                bcol_o,
  output logic                wcol_o
);
  localparam int NLINES = 2;

  start_st_e          st_q;
  logic [CMD_W-1:0]   cmd_q;
  logic [DATA_W-1:0]  txbuf_q;
  logic               hold_q, seen_q, irq_q, bcol_q, wcol_q;
  logic [NLINES-1:0]  lines_s;
  logic               sda_s, scl_s, tick;
  logic               pending, lines_hi;
  logic               begin_ok, begin_bad, abort_ph1, go_ph2, finish, cmd_accept;

  i2c_line_sync #(.W(NLINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (lines_s)
  );

  assign sda_s = lines_s[0];
  assign scl_s = lines_s[1];

  assign pending    = cmd_q[0];
  assign lines_hi   = sda_s && scl_s;
  assign begin_ok   = (st_q == ST_IDLE) && pending && lines_hi;
  assign begin_bad  = (st_q == ST_IDLE) && pending && !lines_hi;
  assign abort_ph1  = (st_q == ST_PH1) && (!scl_s || (tick && !sda_s));
  assign go_ph2     = (st_q == ST_PH1) && tick && lines_hi;
  assign finish     = (st_q == ST_PH2) && tick;
  assign cmd_accept = cmd_wr_i && !pending;

  i2c_baud_cnt #(.CW(RELOAD_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (begin_ok || go_ph2),
    .halt_i (abort_ph1 || finish),
    .val_i  (reload_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (begin_ok) st_q <= ST_PH1;
        ST_PH1:  if (abort_ph1) st_q <= ST_IDLE;
                 else if (go_ph2) st_q <= ST_PH2;
        ST_PH2:  if (finish) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // command register: locked while a START is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (cmd_accept) begin
      cmd_q <= cmd_wdata_i;
    end else if (begin_bad || abort_ph1 || finish) begin
      cmd_q[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txbuf_q <= '0;
      hold_q  <= 1'b0;
      seen_q  <= 1'b0;
      irq_q   <= 1'b0;
      bcol_q  <= 1'b0;
      wcol_q  <= 1'b0;
    end else begin
      if (txbuf_wr_i && !pending) txbuf_q <= txbuf_wdata_i;

      if (go_ph2)          hold_q <= 1'b1;
      else if (cmd_accept) hold_q <= 1'b0;

      if (go_ph2)                      seen_q <= 1'b1;
      else if (begin_ok || begin_bad)  seen_q <= 1'b0;

      if (finish)                    irq_q <= 1'b1;
      else if (flag_clr_i[CLR_IRQ])  irq_q <= 1'b0;

      if (begin_bad || abort_ph1)    bcol_q <= 1'b1;
      else if (flag_clr_i[CLR_BCOL]) bcol_q <= 1'b0;

      if (txbuf_wr_i && pending)     wcol_q <= 1'b1;
      else if (flag_clr_i[CLR_WCOL]) wcol_q <= 1'b0;
    end
  end

  assign sda_pull_o   = hold_q;
  assign cmd_o        = cmd_q;
  assign txbuf_o      = txbuf_q;
  assign start_seen_o = seen_q;
  assign irq_o        = irq_q;
  assign bcol_o       = bcol_q;
  assign wcol_o       = wcol_q;

  assert_pull_with_seen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> start_seen_o);

  assert_irq_on_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($fell(cmd_o[0]) && sda_pull_o));

  assert_txbuf_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[0] && txbuf_wr_i) |=> ($stable(txbuf_o) && wcol_o));

  assert_cmd_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_o[0]) && cmd_o[0]) |-> $stable(cmd_o));

  assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !flag_clr_i[CLR_IRQ]) |=> irq_o);

  assert_bcol_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcol_o && !flag_clr_i[CLR_BCOL]) |=> bcol_o);

  assert_wcol_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_o && !flag_clr_i[CLR_WCOL]) |=> wcol_o);

  assert_abort_no_pull_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcol_o) |-> !sda_pull_o);
endmodule

// File: tb/i2c_start_gen_test.sv
module i2c_start_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] reload = 7'd4;
  logic       cmd_wr = 1'b0;
  logic [4:0] cmd_wdata = '0;
  logic       txbuf_wr = 1'b0;
  logic [7:0] txbuf_wdata = '0;
  logic [2:0] flag_clr = '0;
  logic       sda_ext = 1'b1, scl_ext = 1'b1;
  logic       sda_pull, start_seen, irq, bcol, wcol;
  logic [4:0] cmd;
  logic [7:0] txbuf;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_ext && !sda_pull;

  i2c_start_gen uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .reload_i      (reload),
    .cmd_wr_i      (cmd_wr),
    .cmd_wdata_i   (cmd_wdata),
    .txbuf_wr_i    (txbuf_wr),
    .txbuf_wdata_i (txbuf_wdata),
    .flag_clr_i    (flag_clr),
    .sda_i         (sda_line),
    .scl_i         (scl_ext),
    .sda_pull_o    (sda_pull),
    .cmd_o         (cmd),
    .txbuf_o       (txbuf),
    .start_seen_o  (start_seen),
    .irq_o         (irq),
    .bcol_o        (bcol),
    .wcol_o        (wcol)
  );

  function automatic int exp_pull_delay(int n);
    return n + 2;
  endfunction

  function automatic int exp_done_delay(int n);
    return 2 * n + 3;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cmd(logic [4:0] v);
    cmd_wr = 1'b1;
    cmd_wdata = v;
    tick();
    cmd_wr = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 3'b111;
    tick();
    flag_clr = 3'b000;
  endtask

  // release held SDA, let the synchronizer settle, clear flags
  task automatic prepare(int n);
    reload = n[6:0];
    write_cmd(5'd0);
    repeat (4) tick();
    clear_flags();
  endtask

  // full START with timing measurement
  task automatic run_start(int n);
    int k_pull = 0;
    int k_done = 0;
    prepare(n);
    write_cmd(5'd1);
    for (int k = 1; k < 300 && k_done == 0; k++) begin
      tick();
      if (sda_pull && k_pull == 0) k_pull = k;
      if (irq && k_done == 0) k_done = k;
    end
    check(k_pull == exp_pull_delay(n), "R2 pull delay", k_pull, exp_pull_delay(n));
    check(start_seen, "R2 start flag", start_seen, 1);
    check(k_done == exp_done_delay(n), "R3 done delay", k_done, exp_done_delay(n));
    check(cmd[0] == 1'b0 && sda_pull, "R3 done state", {cmd[0], sda_pull}, 1);
    check(!bcol, "R3 no collision", bcol, 0);
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) tick();
    check(!sda_pull && cmd == 0 && txbuf == 0 && !start_seen && !irq && !bcol && !wcol,
          "R1 reset", {sda_pull, cmd, txbuf, start_seen, irq, bcol, wcol}, 0);
    rst_n = 1'b1;
    tick();

    // directed minimum and maximum reloads, then random ones
    run_start(0);
    run_start(127);
    for (int i = 0; i < 12; i++) run_start(int'($urandom_range(1, 60)));

    // R10: accepted write releases SDA
    write_cmd(5'h04);
    check(!sda_pull, "R10 release", sda_pull, 0);
    check(cmd == 5'h04, "R10 cmd stored", cmd, 4);

    // R9: sticky irq, cleared only by its own bit
    prepare(3);
    write_cmd(5'd1);
    repeat (exp_done_delay(3)) tick();
    flag_clr = 3'b110;
    tick();
    flag_clr = 3'b000;
    repeat (3) tick();
    check(irq, "R9 irq sticky", irq, 1);
    flag_clr = 3'b001;
    tick();
    flag_clr = 3'b000;
    check(!irq, "R9 irq clear", irq, 0);

    // R7 and R8 during a START
    prepare(20);
    txbuf_wr = 1'b1;
    txbuf_wdata = 8'h5A;
    tick();
    txbuf_wr = 1'b0;
    check(txbuf == 8'h5A && !wcol, "R7 store idle", txbuf, 8'h5A);
    write_cmd(5'd1);
    repeat (3) tick();
    txbuf_wr = 1'b1;
    txbuf_wdata = 8'hC3;
    tick();
    txbuf_wr = 1'b0;
    check(txbuf == 8'h5A, "R7 buffer kept", txbuf, 8'h5A);
    check(wcol, "R7 wcol set", wcol, 1);
    write_cmd(5'h1E);
    check(cmd == 5'h01, "R8 cmd locked", cmd, 1);
    repeat (60) tick();
    check(cmd == 5'h00 && irq, "R8 cmd after done", cmd, 0);
    repeat (5) tick();
    check(wcol, "R9 wcol sticky", wcol, 1);
    flag_clr = 3'b100;
    tick();
    flag_clr = 3'b000;
    check(!wcol, "R9 wcol clear", wcol, 0);

    // R4: SCL low when START requested
    prepare(10);
    scl_ext = 1'b0;
    repeat (3) tick();
    write_cmd(5'd1);
    repeat (4) tick();
    check(bcol && cmd[0] == 1'b0, "R4 collision", {bcol, cmd[0]}, 2);
    check(!sda_pull && !start_seen, "R4 no start", {sda_pull, start_seen}, 0);
    scl_ext = 1'b1;

    // R4: SDA low when START requested
    prepare(10);
    sda_ext = 1'b0;
    repeat (3) tick();
    write_cmd(5'd1);
    repeat (4) tick();
    check(bcol && !sda_pull && cmd[0] == 1'b0, "R4 sda low", {bcol, sda_pull, cmd[0]}, 2);
    sda_ext = 1'b1;

    // R5: SCL drops in first phase
    prepare(20);
    write_cmd(5'd1);
    repeat (5) tick();
    scl_ext = 1'b0;
    repeat (4) tick();
    check(bcol && cmd[0] == 1'b0, "R5 collision", {bcol, cmd[0]}, 2);
    repeat (30) tick();
    check(!sda_pull && !start_seen && !irq, "R5 aborted", {sda_pull, start_seen, irq}, 0);
    scl_ext = 1'b1;

    // R6: SDA low at first timeout
    prepare(12);
    write_cmd(5'd1);
    repeat (6) tick();
    sda_ext = 1'b0;
    repeat (12) tick();
    check(bcol && cmd[0] == 1'b0, "R6 collision", {bcol, cmd[0]}, 2);
    sda_ext = 1'b1;
    repeat (20) tick();
    check(!sda_pull && !start_seen, "R6 aborted", {sda_pull, start_seen}, 0);

    // R9: bcol sticky until its own clear bit
    flag_clr = 3'b101;
    tick();
    flag_clr = 3'b000;
    check(bcol, "R9 bcol sticky", bcol, 1);
    flag_clr = 3'b010;
    tick();
    flag_clr = 3'b000;
    check(!bcol, "R9 bcol clear", bcol, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule